// File: doc/BRIEF.md
# Predicate-Pair Integer Compare Unit

This unit evaluates one integer relation between two operands and records the Boolean outcome as a complementary pair in a small predicate register file. The operation is taken on a single-cycle valid strobe. The first named predicate receives the outcome and the second receives its inverse. Both writes land on the clock edge that samples the strobe. Predicate 0 is a constant true, so software can name it as a placeholder destination when only one polarity is needed.

The relation is applied over either the full 64-bit operands or only their low 32 bits, and under signed or unsigned ordering. The first operand can be a register, a sign-extended 8-bit immediate or the zero register. The second operand can be a register or the zero register. Inside, the unit has only one equality comparator and one less-than comparator. Every other relation is built by exchanging the operands, inverting the result pair, or decrementing an immediate first operand. A combinational read port returns any predicate.

Top module: `pred_cmp_unit`

## Requirements
- R1: When `valid_i` is high and the operation is legal, the predicate named by `pdst1_i` becomes the outcome and the one named by `pdst2_i` becomes its inverse. Both are visible on the read port after the next rising clock edge.
- R2: Predicate 0 always reads 1. If predicate 0 is named as a destination, its write is dropped, and the other destination is still written.
- R3: With `unsigned_i`=0, relation codes 0..5 mean equal, not equal, less, less-or-equal, greater-or-equal and greater, under two's complement ordering.
- R4: With `unsigned_i`=1, codes 2..5 use unsigned ordering. Codes 0 and 1 give the same result in both modes.
- R5: With `narrow_i`=1, only bits 31:0 of each operand take part, and bit 31 is the sign. With `narrow_i`=0, all 64 bits take part.
- R6: `form_i` selects the operands. 0: a=`src_a_i`, b=`src_b_i`. 1: a=immediate, b=`src_b_i`. 2: a=0, b=`src_b_i`. 3: a=`src_a_i`, b=0.
- R7: The 8-bit `imm_i` is sign-extended before use. In narrow mode, the low 32 bits of the extended value are used.
- R8: Ordering follows the selected signedness on identical bit patterns. For 0xC000_0000_0000_0000 versus 0x6000_0000_0000_0000, the signed result is less and the unsigned result is greater.
- R9: For less-or-equal with an immediate first operand, the result is correct even when the immediate is the minimum of the active ordering. For example, an unsigned immediate 0 gives true for every b.
- R10: `illegal_o` is high exactly when `valid_i` is high and either both destinations are equal or the relation code is 6 or 7. No predicate changes in that case.
- R11: After reset, every predicate except predicate 0 reads 0.
- R12: While `valid_i` is low, no predicate changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Compare strobe |
| rel_i | input | 3 | Relation code |
| unsigned_i | input | 1 | 1 selects unsigned ordering |
| narrow_i | input | 1 | 1 selects 32-bit compare |
| form_i | input | 2 | Operand form |
| src_a_i | input | 64 | First register operand |
| src_b_i | input | 64 | Second register operand |
| imm_i | input | 8 | Immediate first operand |
| pdst1_i | input | 6 | Destination for the outcome |
| pdst2_i | input | 6 | Destination for the inverse |
| rd_addr_i | input | 6 | Read port index |
| rd_data_o | output | 1 | Predicate read value |
| illegal_o | output | 1 | Rejected operation flag |

## Verification
The assertions take for granted that every input is a known value while reset is released. They also assume the read index stays constant over any pair of cycles in which the read value is compared. The bench only moves the read index while the strobe is low, and it changes it between samples, not across an edge, so each comparison window sees a fixed index. The operand sweep is kept to signedness boundaries, the 32-bit seam and the immediate extremes, where a wrong operand swap or a missed decrement shows up.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [2:0] {
      REL_EQ = 3'd0,
      REL_NE = 3'd1,
      REL_LT = 3'd2,
      REL_LE = 3'd3,
      REL_GE = 3'd4,
      REL_GT = 3'd5
   } rel_e;

   typedef enum logic [1:0] {
      FORM_RR = 2'd0,
      FORM_IR = 2'd1,
      FORM_ZR = 2'd2,
      FORM_RZ = 2'd3
   } form_e;
endpackage

// File: rtl/pcu_operand_sel.sv
module pcu_operand_sel #(
   parameter int XLEN  = 64,
   parameter int LOW_W = 32,
   parameter int IMM_W = 8
) (
   input  logic [1:0]      form,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic [IMM_W-1:0] imm,
   input  logic            narrow,
   input  logic            is_unsigned,
   output logic [XLEN-1:0] key_a,
   output logic [XLEN-1:0] key_b,
   output logic            a_is_imm
);
   import pcu_pkg::*;

   localparam int EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] raw_a, raw_b;

   // Map a value onto a key whose unsigned order equals the requested order.
   function automatic logic [XLEN-1:0] to_key(input logic [XLEN-1:0] x,
                                               input logic nar,
                                               input logic uns);
      logic [XLEN-1:0] k;
      if (nar) begin
         k = '0;
         k[LOW_W-1:0] = x[LOW_W-1:0];
         k[LOW_W-1]   = x[LOW_W-1] ^ ~uns;
      end else begin
         k = x;
         k[XLEN-1] = x[XLEN-1] ^ ~uns;
      end
      return k;
   endfunction

   always_comb begin
      a_is_imm = 1'b0;
      raw_b    = src_b;
      case (form_e'(form))
         FORM_RR: raw_a = src_a;
         FORM_IR: begin
            raw_a    = {{EXT_W{imm[IMM_W-1]}}, imm};
            a_is_imm = 1'b1;
         end
         FORM_ZR: raw_a = '0;
         default: begin
            raw_a = src_a;
            raw_b = '0;
         end
      endcase
      key_a = to_key(raw_a, narrow, is_unsigned);
      key_b = to_key(raw_b, narrow, is_unsigned);
   end
endmodule

// File: rtl/pcu_rel_core.sv
module pcu_rel_core #(
   parameter int XLEN = 64
) (
   input  logic [2:0]      rel,
   input  logic [XLEN-1:0] key_a,
   input  logic [XLEN-1:0] key_b,
   input  logic            a_is_imm,
   output logic            outcome,
   output logic            bad_rel
);
   import pcu_pkg::*;

   logic [XLEN-1:0] lhs, rhs, a_dec;
   logic use_eq, flip, force_true, eq_hit, lt_hit, a_floor;

   assign a_dec   = key_a - 1'b1;
   assign a_floor = (key_a == '0);
   assign eq_hit  = (key_a == key_b);
   assign lt_hit  = (lhs < rhs);

   always_comb begin
      lhs        = key_a;
      rhs        = key_b;
      use_eq     = 1'b0;
      flip       = 1'b0;
      force_true = 1'b0;
      bad_rel    = 1'b0;
      case (rel)
         REL_EQ: use_eq = 1'b1;
         REL_NE: begin use_eq = 1'b1; flip = 1'b1; end
         REL_LT: ;
         REL_GE: flip = 1'b1;
         REL_GT: begin lhs = key_b; rhs = key_a; end
         REL_LE: begin
            if (a_is_imm) begin
               lhs        = a_dec;
               force_true = a_floor;
            end else begin
               lhs  = key_b;
               rhs  = key_a;
               flip = 1'b1;
            end
         end
         default: bad_rel = 1'b1;
      endcase
   end

   assign outcome = force_true | ((use_eq ? eq_hit : lt_hit) ^ flip);
endmodule

// File: rtl/pcu_pred_file.sv
module pcu_pred_file #(
   parameter int NPRED = 64,
   localparam int AW   = $clog2(NPRED)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa1,
   input  logic          wd1,
   input  logic [AW-1:0] wa2,
   input  logic          wd2,
   input  logic [AW-1:0] ra,
   output logic          rd
);
   logic [NPRED-1:0] pr;

   for (genvar i = 0; i < NPRED; i++) begin : g_bit
      if (i == 0) begin : g_const
         assign pr[i] = 1'b1;
      end else begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      q <= 1'b0;
            else if (we && wa1 == AW'(i))    q <= wd1;
            else if (we && wa2 == AW'(i))    q <= wd2;
         end
         assign pr[i] = q;
      end
   end

   assign rd = pr[ra];
endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit #(
   parameter int XLEN  = 64,
   parameter int LOW_W = 32,
   parameter int IMM_W = 8,
   parameter int NPRED = 64,
   localparam int AW   = $clog2(NPRED)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid_i,
   input  logic [2:0]      rel_i,
   input  logic            unsigned_i,
   input  logic            narrow_i,
   input  logic [1:0]      form_i,
   input  logic [XLEN-1:0] src_a_i,
   input  logic [XLEN-1:0] src_b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [AW-1:0]   pdst1_i,
   input  logic [AW-1:0]   pdst2_i,
   input  logic [AW-1:0]   rd_addr_i,
   output logic            rd_data_o,
   output logic            illegal_o
);
   if (LOW_W >= XLEN || LOW_W < 2) begin : g_bad_low
      $error("pred_cmp_unit: LOW_W must lie in [2, XLEN)");
   end
   if (IMM_W > LOW_W || IMM_W < 2) begin : g_bad_imm
      $error("pred_cmp_unit: IMM_W must lie in [2, LOW_W]");
   end
   if (NPRED < 2 || (1 << AW) != NPRED) begin : g_bad_np
      $error("pred_cmp_unit: NPRED must be a power of two of at least 2");
   end

   logic [XLEN-1:0] key_a, key_b;
   logic a_is_imm, outcome, bad_rel, commit;

   pcu_operand_sel #(.XLEN(XLEN), .LOW_W(LOW_W), .IMM_W(IMM_W)) u_sel (
      .form(form_i), .src_a(src_a_i), .src_b(src_b_i), .imm(imm_i),
      .narrow(narrow_i), .is_unsigned(unsigned_i),
      .key_a(key_a), .key_b(key_b), .a_is_imm(a_is_imm)
   );

   pcu_rel_core #(.XLEN(XLEN)) u_core (
      .rel(rel_i), .key_a(key_a), .key_b(key_b), .a_is_imm(a_is_imm),
      .outcome(outcome), .bad_rel(bad_rel)
   );

   assign illegal_o = valid_i & ((pdst1_i == pdst2_i) | bad_rel);
   assign commit    = valid_i & ~illegal_o;

   pcu_pred_file #(.NPRED(NPRED)) u_pf (
      .clk(clk), .rst_n(rst_n), .we(commit),
      .wa1(pdst1_i), .wd1(outcome), .wa2(pdst2_i), .wd2(~outcome),
      .ra(rd_addr_i), .rd(rd_data_o)
   );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          valid_i,
   input logic [2:0]    rel_i,
   input logic [AW-1:0] pdst1_i,
   input logic [AW-1:0] pdst2_i,
   input logic [AW-1:0] rd_addr_i,
   input logic          rd_data_o,
   input logic          illegal_o
);
   assert_p0_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_i == '0) |-> rd_data_o);

   assert_same_dst_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && pdst1_i == pdst2_i) |-> illegal_o);

   assert_reserved_rel_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && rel_i[2:1] == 2'b11) |-> illegal_o);

   assert_flag_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |-> !illegal_o);

   assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!valid_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

   assert_illegal_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(illegal_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind pred_cmp_unit pcu_checker #(.AW(AW)) u_chk (.*);

// File: tb/sim_pred_cmp_unit.sv
module sim_pred_cmp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  rel_i = '0;
   logic        unsigned_i = 1'b0, narrow_i = 1'b0;
   logic [1:0]  form_i = '0;
   logic [63:0] src_a_i = '0, src_b_i = '0;
   logic [7:0]  imm_i = '0;
   logic [5:0]  pdst1_i = 6'd1, pdst2_i = 6'd2, rd_addr_i = '0;
   logic        rd_data_o, illegal_o;

   int checks = 0, fails = 0;

   always #10 clk = ~clk;

   pred_cmp_unit u0 (.*);

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] opv(input int i);
      case (i)
         0: return 64'h0;
         1: return 64'h1;
         2: return '1;
         3: return 64'h8000_0000_0000_0000;
         4: return 64'h7FFF_FFFF_FFFF_FFFF;
         5: return 64'h0000_0000_8000_0000;
         6: return 64'hC000_0000_0000_0000;
         7: return 64'h6000_0000_0000_0000;
         8: return 64'hFFFF_FFFF_0000_0005;
         9: return 64'h0000_0001_0000_0005;
         default: return 64'h5;
      endcase
   endfunction

   function automatic logic [7:0] immv(input int i);
      case (i)
         0: return 8'h00; 1: return 8'h01; 2: return 8'hFF; 3: return 8'h80;
         4: return 8'h7F; 5: return 8'h05; 6: return 8'hFE; 7: return 8'h81;
         8: return 8'h02; 9: return 8'hC0; default: return 8'h40;
      endcase
   endfunction

   // Reference outcome from plain arithmetic on 65-bit signed values.
   function automatic logic model(input logic [2:0] rel, input logic uns, input logic nar,
                                  input logic [1:0] form, input logic [63:0] a,
                                  input logic [63:0] b, input logic [7:0] imm);
      logic [63:0] ra, rb;
      logic signed [64:0] va, vb;
      ra = (form == 2'd0 || form == 2'd3) ? a :
           (form == 2'd1) ? {{56{imm[7]}}, imm} : 64'h0;
      rb = (form == 2'd3) ? 64'h0 : b;
      if (nar) begin
         va = uns ? {33'b0, ra[31:0]} : {{33{ra[31]}}, ra[31:0]};
         vb = uns ? {33'b0, rb[31:0]} : {{33{rb[31]}}, rb[31:0]};
      end else begin
         va = uns ? {1'b0, ra} : {ra[63], ra};
         vb = uns ? {1'b0, rb} : {rb[63], rb};
      end
      case (rel)
         3'd0: return va == vb;
         3'd1: return va != vb;
         3'd2: return va < vb;
         3'd3: return va <= vb;
         3'd4: return va >= vb;
         default: return va > vb;
      endcase
   endfunction

   task automatic rd(input logic [5:0] idx, output logic v);
      rd_addr_i = idx;
      #1 v = rd_data_o;
   endtask

   // Issue one operation; returns the values read at both destinations afterwards.
   task automatic issue(input logic [2:0] rel, input logic uns, input logic nar,
                        input logic [1:0] form, input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] imm, input logic [5:0] d1, input logic [5:0] d2,
                        output logic ill, output logic v1, output logic v2);
      @(negedge clk);
      rel_i = rel; unsigned_i = uns; narrow_i = nar; form_i = form;
      src_a_i = a; src_b_i = b; imm_i = imm; pdst1_i = d1; pdst2_i = d2;
      valid_i = 1'b1;
      #1 ill = illegal_o;
      @(negedge clk);
      valid_i = 1'b0;
      rd(d1, v1);
      rd(d2, v2);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic ill, v1, v2, e, t;
      int n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state of the whole file, p0 forced to 1
      for (int i = 0; i < 64; i++) begin
         rd(6'(i), t);
         chk(i == 0 ? "R2 p0 after reset" : "R11 reset value", t, i == 0);
      end

      // R1 R3 R4 R5 R6 R7 R9: sweep of relations, modes, forms and corner operands
      for (int rel = 0; rel < 6; rel++)
         for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++)
               for (int i = 0; i < 11; i++)
                  for (int j = 0; j < 11; j++) begin
                     logic [5:0] d1, d2;
                     d1 = 6'(1 + (n % 63));
                     d2 = 6'(1 + ((n + 7) % 63));
                     n++;
                     e = model(3'(rel), m[0], m[1], 2'(f), opv(i), opv(j), immv(i));
                     issue(3'(rel), m[0], m[1], 2'(f), opv(i), opv(j), immv(i), d1, d2, ill, v1, v2);
                     chk("R1 R3 R4 R5 R6 R7 first dest", v1, e);
                     chk("R1 second dest inverse", v2, ~e);
                  end

      // R8: same bit patterns, opposite order by signedness
      issue(3'd2, 1'b0, 1'b0, 2'd0, 64'hC000_0000_0000_0000, 64'h6000_0000_0000_0000,
            8'h0, 6'd3, 6'd4, ill, v1, v2);
      chk("R8 signed less", v1, 1'b1);
      issue(3'd5, 1'b1, 1'b0, 2'd0, 64'hC000_0000_0000_0000, 64'h6000_0000_0000_0000,
            8'h0, 6'd3, 6'd4, ill, v1, v2);
      chk("R8 unsigned greater", v1, 1'b1);

      // R9: unsigned immediate 0 at the ordering floor
      issue(3'd3, 1'b1, 1'b0, 2'd1, 64'h0, 64'h0, 8'h00, 6'd10, 6'd11, ill, v1, v2);
      chk("R9 leu imm 0 vs 0", v1, 1'b1);
      issue(3'd3, 1'b1, 1'b1, 2'd1, 64'h0, 64'hFFFF_FFFF_0000_0000, 8'h00, 6'd10, 6'd11, ill, v1, v2);
      chk("R9 leu imm 0 narrow", v1, 1'b1);
      issue(3'd3, 1'b0, 1'b0, 2'd1, 64'h0, 64'h8000_0000_0000_0000, 8'h80, 6'd10, 6'd11, ill, v1, v2);
      chk("R9 le imm -128 vs min", v1, 1'b0);

      // R2: p0 as a destination
      issue(3'd0, 1'b0, 1'b0, 2'd0, 64'h7, 64'h7, 8'h0, 6'd0, 6'd9, ill, v1, v2);
      chk("R2 p0 stays one", v1, 1'b1);
      chk("R2 partner written", v2, 1'b0);
      chk("R2 no flag", ill, 1'b0);
      issue(3'd1, 1'b0, 1'b0, 2'd0, 64'h7, 64'h7, 8'h0, 6'd9, 6'd0, ill, v1, v2);
      chk("R2 partner first", v1, 1'b0);
      chk("R2 p0 stays one second", v2, 1'b1);

      // R10: same destination twice, then a reserved relation code
      issue(3'd0, 1'b0, 1'b0, 2'd0, 64'h1, 64'h1, 8'h0, 6'd5, 6'd6, ill, v1, v2);
      chk("R10 preload p5", v1, 1'b1);
      issue(3'd1, 1'b0, 1'b0, 2'd0, 64'h1, 64'h1, 8'h0, 6'd5, 6'd5, ill, v1, v2);
      chk("R10 same dest flagged", ill, 1'b1);
      chk("R10 same dest no write", v1, 1'b1);
      issue(3'd6, 1'b0, 1'b0, 2'd0, 64'h1, 64'h2, 8'h0, 6'd5, 6'd6, ill, v1, v2);
      chk("R10 code 6 flagged", ill, 1'b1);
      chk("R10 code 6 p5 kept", v1, 1'b1);
      chk("R10 code 6 p6 kept", v2, 1'b0);
      issue(3'd7, 1'b0, 1'b0, 2'd0, 64'h1, 64'h2, 8'h0, 6'd6, 6'd5, ill, v1, v2);
      chk("R10 code 7 flagged", ill, 1'b1);
      chk("R10 code 7 p6 kept", v1, 1'b0);

      // R12: inputs toggle without the strobe
      @(negedge clk);
      rel_i = 3'd1; form_i = 2'd0; src_a_i = 64'h1; src_b_i = 64'h2;
      pdst1_i = 6'd5; pdst2_i = 6'd6;
      #1 chk("R12 no flag when idle", illegal_o, 1'b0);
      repeat (2) @(negedge clk);
      rd(6'd5, v1);
      rd(6'd6, v2);
      chk("R12 p5 unchanged", v1, 1'b1);
      chk("R12 p6 unchanged", v2, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule